// File: doc/BRIEF.md
# Vertical Line-Shift Phase Generator

This block moves one line of an image-sensor array into its horizontal output register. A single `line_start` pulse starts the line. The block then counts pixel-clock periods and drives four overlapping image-section clock phases and a transfer-gate signal on a fixed schedule. It marks the first cycle of the line with a sync pulse. At a fixed count it signals that horizontal readout may begin. It ends the line with a one-cycle done pulse at the last count and then returns to idle.

The line length depends on how many output amplifiers are used. In single-output mode a line is 2975 pixel periods long, and in dual-output mode it is 1721 periods long (at 25 MHz, 119 µs and 68.84 µs). In sub-sample mode the transfer gate stays low for the whole line. The vertical phases still run, so the line is shifted without being moved into the register.

Both mode inputs are sampled once, in the cycle that accepts `line_start`. The frame sequencer above the block and the horizontal clocking below it talk to the block only through the start, sync, readout-start and done pins.

Top module: `vline_shift_gen`

## Requirements
- R1: After reset, and whenever no line is in progress, `busy`, `img_phase`, `xfer_gate`, `line_sync`, `hread_start` and `line_done` are all low.
- R2: A `line_start` seen at a clock edge while idle starts a line. In the following cycle (count 0) `busy` is high and `line_sync` is high for exactly that one cycle.
- R3: Bit k of `img_phase` (k=0 is the first phase, k=3 the last) is high for counts 84+42k through 84+42(k+5)-1, and low at every other count. Each phase is therefore high for 5 of the 8 steps of 42 counts between counts 84 and 420, and each phase starts one step after the previous one.
- R4: In normal mode (`subsample` low at line start), `xfer_gate` equals `img_phase[0]` in every cycle of the line.
- R5: In sub-sample mode (`subsample` high at line start), `xfer_gate` is low for the whole line. `img_phase` follows R3 unchanged.
- R6: `hread_start` is high for exactly one cycle, at count 460.
- R7: The line's last count is 2974 when `dual_out_mode` was low at line start, and 1720 when it was high. `line_done` is high only at that count, and `busy` falls in the next cycle.
- R8: Changes to `dual_out_mode` or `subsample` during a line have no effect on that line's outputs or length.
- R9: A `line_start` that arrives while `busy` is high, up to and including the `line_done` cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Request to shift one line; acted on only when idle |
| dual_out_mode | input | 1 | 1 selects the short (dual-output) line length; sampled at line start |
| subsample | input | 1 | 1 holds the transfer gate low for the line; sampled at line start |
| img_phase | output | 4 | Image-section clock phases, bit 0 first |
| xfer_gate | output | 1 | Transfer-gate drive |
| line_sync | output | 1 | One-cycle pulse at count 0 |
| hread_start | output | 1 | One-cycle pulse at count 460, handing over to horizontal readout |
| line_done | output | 1 | One-cycle pulse at the line's last count |
| busy | output | 1 | High while a line is in progress |

## Verification
The assertions check the following on every cycle:
- The outputs are quiet while idle.
- The transfer gate is never high without the first phase.
- The three event pulses never coincide.
- Each phase starts and ends in the right order relative to its neighbours.
- Once a line starts, it runs until `line_done` and then drops `busy`.
- The latched mode stays fixed for the whole line.

The exact counts cannot be expressed as assertions, so the bench's scenarios show them: every phase edge, the readout-start position, and the two line lengths. The bench's scenarios also show the sub-sample behaviour, and that mid-line mode changes and stray start requests leave the line untouched.

// File: rtl/vls_pkg.sv
package vls_pkg;

  // Default schedule, in pixel-clock periods
  localparam int unsigned DEF_LEN_SINGLE = 2975;
  localparam int unsigned DEF_LEN_DUAL   = 1721;
  localparam int unsigned DEF_FIRST_EDGE = 84;
  localparam int unsigned DEF_STEP       = 42;
  localparam int unsigned DEF_HIGH_STEPS = 5;
  localparam int unsigned DEF_NUM_PHASES = 4;
  localparam int unsigned DEF_HREAD_AT   = 460;

  // Modes latched once per line
  typedef struct packed {
    logic dual;
    logic sub;
  } line_mode_t;

  // Count at which phase k rises
  function automatic int unsigned phase_rise(int unsigned first, int unsigned step, int unsigned k);
    return first + k * step;
  endfunction

  // First count at which phase k is low again
  function automatic int unsigned phase_fall(int unsigned first, int unsigned step,
                                             int unsigned high_steps, int unsigned k);
    return first + (k + high_steps) * step;
  endfunction

endpackage

// File: rtl/vls_line_counter.sv
module vls_line_counter
  import vls_pkg::*;
#(
  parameter int unsigned CW         = 12,
  parameter int unsigned LEN_SINGLE = DEF_LEN_SINGLE,
  parameter int unsigned LEN_DUAL   = DEF_LEN_DUAL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  line_mode_t    mode_i,
  output logic          busy_o,
  output logic [CW-1:0] cnt_o,
  output line_mode_t    mode_q_o,
  output logic          last_o
);

  localparam logic [CW-1:0] LAST_SINGLE = CW'(LEN_SINGLE - 1);
  localparam logic [CW-1:0] LAST_DUAL   = CW'(LEN_DUAL - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  line_mode_t    mode_q;
  logic [CW-1:0] limit;
  logic          at_last;

  assign limit   = mode_q.dual ? LAST_DUAL : LAST_SINGLE;
  assign at_last = busy_q && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      mode_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        mode_q <= mode_i;
      end
    end else if (at_last) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign cnt_o    = cnt_q;
  assign mode_q_o = mode_q;
  assign last_o   = at_last;

endmodule

// File: rtl/vls_phase_bank.sv
module vls_phase_bank
  import vls_pkg::*;
#(
  parameter int unsigned CW         = 12,
  parameter int unsigned NUM_PHASES = DEF_NUM_PHASES,
  parameter int unsigned FIRST_EDGE = DEF_FIRST_EDGE,
  parameter int unsigned STEP       = DEF_STEP,
  parameter int unsigned HIGH_STEPS = DEF_HIGH_STEPS
) (
  input  logic                  busy_i,
  input  logic [CW-1:0]         cnt_i,
  input  logic                  sub_i,
  output logic [NUM_PHASES-1:0] phase_o,
  output logic                  xfer_o
);

  for (genvar k = 0; k < NUM_PHASES; k++) begin : g_phase
    localparam logic [CW-1:0] RISE = CW'(phase_rise(FIRST_EDGE, STEP, k));
    localparam logic [CW-1:0] FALL = CW'(phase_fall(FIRST_EDGE, STEP, HIGH_STEPS, k));
    assign phase_o[k] = busy_i && (cnt_i >= RISE) && (cnt_i < FALL);
  end

  // Transfer gate mirrors the first phase unless sub-sampling
  assign xfer_o = phase_o[0] && !sub_i;

endmodule

// File: rtl/vls_event_tap.sv
module vls_event_tap
  import vls_pkg::*;
#(
  parameter int unsigned CW       = 12,
  parameter int unsigned HREAD_AT = DEF_HREAD_AT
) (
  input  logic          busy_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          last_i,
  output logic          sync_o,
  output logic          hread_o,
  output logic          done_o
);

  localparam logic [CW-1:0] HREAD_CNT = CW'(HREAD_AT);

  assign sync_o  = busy_i && (cnt_i == '0);
  assign hread_o = busy_i && (cnt_i == HREAD_CNT);
  assign done_o  = last_i;

endmodule

// File: rtl/vline_shift_gen.sv
module vline_shift_gen
  import vls_pkg::*;
#(
  parameter int unsigned LEN_SINGLE = DEF_LEN_SINGLE,
  parameter int unsigned LEN_DUAL   = DEF_LEN_DUAL,
  parameter int unsigned FIRST_EDGE = DEF_FIRST_EDGE,
  parameter int unsigned STEP       = DEF_STEP,
  parameter int unsigned HIGH_STEPS = DEF_HIGH_STEPS,
  parameter int unsigned NUM_PHASES = DEF_NUM_PHASES,
  parameter int unsigned HREAD_AT   = DEF_HREAD_AT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  line_start,
  input  logic                  dual_out_mode,
  input  logic                  subsample,
  output logic [NUM_PHASES-1:0] img_phase,
  output logic                  xfer_gate,
  output logic                  line_sync,
  output logic                  hread_start,
  output logic                  line_done,
  output logic                  busy
);

  localparam int unsigned MAX_LEN = (LEN_SINGLE > LEN_DUAL) ? LEN_SINGLE : LEN_DUAL;
  localparam int unsigned CW      = $clog2(MAX_LEN + 1);

  line_mode_t    mode_in;
  line_mode_t    mode_q;
  logic [CW-1:0] cnt;
  logic          at_last;

  assign mode_in.dual = dual_out_mode;
  assign mode_in.sub  = subsample;

  vls_line_counter #(
    .CW         (CW),
    .LEN_SINGLE (LEN_SINGLE),
    .LEN_DUAL   (LEN_DUAL)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (line_start),
    .mode_i   (mode_in),
    .busy_o   (busy),
    .cnt_o    (cnt),
    .mode_q_o (mode_q),
    .last_o   (at_last)
  );

  vls_phase_bank #(
    .CW         (CW),
    .NUM_PHASES (NUM_PHASES),
    .FIRST_EDGE (FIRST_EDGE),
    .STEP       (STEP),
    .HIGH_STEPS (HIGH_STEPS)
  ) u_phases (
    .busy_i  (busy),
    .cnt_i   (cnt),
    .sub_i   (mode_q.sub),
    .phase_o (img_phase),
    .xfer_o  (xfer_gate)
  );

  vls_event_tap #(
    .CW       (CW),
    .HREAD_AT (HREAD_AT)
  ) u_events (
    .busy_i  (busy),
    .cnt_i   (cnt),
    .last_i  (at_last),
    .sync_o  (line_sync),
    .hread_o (hread_start),
    .done_o  (line_done)
  );

endmodule

// File: rtl/vline_shift_gen_checker.sv
module vline_shift_gen_checker #(
  parameter int unsigned NUM_PHASES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_PHASES-1:0] img_phase,
  input logic                  xfer_gate,
  input logic                  line_sync,
  input logic                  hread_start,
  input logic                  line_done,
  input logic                  busy,
  input logic [1:0]            mode_latched
);

  // R1: quiet while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (img_phase == '0) && !xfer_gate && !line_sync && !hread_start && !line_done);

  // R2: a new line always opens with the sync pulse
  assert_sync_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> line_sync);

  // R3: phase k+1 rises while phase k is already high
  for (genvar k = 1; k < NUM_PHASES; k++) begin : g_order
    assert_phase_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(img_phase[k]) |-> img_phase[k-1]);
  end

  // R3: first phase falls while last phase is still high
  assert_phase_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(img_phase[0]) && busy |-> img_phase[NUM_PHASES-1]);

  // R4/R5: transfer gate never without the first phase
  assert_xfer_follows_a1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_gate |-> img_phase[0]);

  // R6: event pulses never coincide
  assert_events_distinct_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({line_sync, hread_start, line_done}));

  // R7: done ends the line
  assert_done_ends_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !busy);

  // R9: a line runs without interruption until done
  assert_no_early_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !line_done |=> busy);

  // R8: latched mode held across the line
  assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mode_latched));

endmodule

bind vline_shift_gen vline_shift_gen_checker #(
  .NUM_PHASES (NUM_PHASES)
) u_vline_shift_gen_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .img_phase    (img_phase),
  .xfer_gate    (xfer_gate),
  .line_sync    (line_sync),
  .hread_start  (hread_start),
  .line_done    (line_done),
  .busy         (busy),
  .mode_latched ({mode_q.dual, mode_q.sub})
);

// File: tb/vline_shift_gen_bench.sv
module vline_shift_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_start = 1'b0;
  logic       dual_out_mode = 1'b0;
  logic       subsample = 1'b0;
  logic [3:0] img_phase;
  logic       xfer_gate, line_sync, hread_start, line_done, busy;

  int vectors = 0;
  int fails   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  vline_shift_gen u_vline_shift_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_start    (line_start),
    .dual_out_mode (dual_out_mode),
    .subsample     (subsample),
    .img_phase     (img_phase),
    .xfer_gate     (xfer_gate),
    .line_sync     (line_sync),
    .hread_start   (hread_start),
    .line_done     (line_done),
    .busy          (busy)
  );

  // Expected {phase[3:0], xfer, sync, hread, done, busy} at count n of a line
  function automatic logic [8:0] expect_vec(int n, int last, bit sub);
    logic [3:0] ph;
    if (n > last) return '0;
    for (int k = 0; k < 4; k++)
      ph[k] = (n >= 84 + 42*k) && (n < 84 + 42*(k+5));
    return {ph, ph[0] && !sub, n == 0, n == 460, n == last, 1'b1};
  endfunction

  function automatic string blame(logic [8:0] diff, bit sub);
    if (diff[8:5] != 0) return "R3";
    if (diff[4])        return sub ? "R5" : "R4";
    if (diff[3])        return "R2";
    if (diff[2])        return "R6";
    if (diff[1:0] != 0) return "R7";
    return "R1";
  endfunction

  task automatic check_cycle(int n, int last, bit sub, string ctx);
    logic [8:0] act, exp;
    act = {img_phase, xfer_gate, line_sync, hread_start, line_done, busy};
    exp = expect_vec(n, last, sub);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) count %0d: actual %b expected %b",
               blame(act ^ exp, sub), ctx, n, act, exp);
    end
  endtask

  task automatic check_idle(string tag);
    logic [8:0] act;
    act = {img_phase, xfer_gate, line_sync, hread_start, line_done, busy};
    vectors++;
    if (act !== '0) begin
      fails++;
      $display("FAIL %s idle: actual %b expected %b", tag, act, 9'b0);
    end
  endtask

  // Run one line; optional mid-line mode changes (R8) and stray starts (R9)
  task automatic run_line(bit d, bit s, bit wiggle, bit strays, string ctx);
    int last = d ? 1720 : 2974;
    int busy_cnt = 0;
    @(negedge clk);
    dual_out_mode = d; subsample = s; line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    for (int n = 0; n <= last + 1; n++) begin
      check_cycle(n, last, s, ctx);
      if (busy) busy_cnt++;
      if (wiggle) begin
        dual_out_mode = 1'($urandom);
        subsample     = 1'($urandom);
      end
      line_start = (strays && n < last - 1) ? (($urandom % 40) == 0) : 1'b0;
      @(negedge clk);
    end
    line_start = 1'b0;
    vectors++;
    if (busy_cnt != last + 1) begin
      fails++;
      $display("FAIL R7 (%s%s%s) line length: actual %0d expected %0d", ctx,
               wiggle ? " R8" : "", strays ? " R9" : "", busy_cnt, last + 1);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1207));
    // R1: reset state
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");

    // Directed: every mode pairing
    run_line(1'b0, 1'b0, 1'b0, 1'b0, "single normal R3 R4");
    run_line(1'b0, 1'b1, 1'b0, 1'b0, "single subsample R5");
    run_line(1'b1, 1'b0, 1'b0, 1'b0, "dual normal R7");
    run_line(1'b1, 1'b1, 1'b0, 1'b0, "dual subsample R5");

    // Mode changes mid-line (R8) and starts while busy (R9)
    run_line(1'b0, 1'b0, 1'b1, 1'b0, "mode wiggle R8");
    run_line(1'b1, 1'b1, 1'b1, 1'b1, "stray starts R9");

    // Random lines
    for (int i = 0; i < 4; i++)
      run_line(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "random");

    // R1: reset in mid-line returns to idle
    @(negedge clk);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    repeat (300) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule